// File: doc/BRIEF.md
# Transmit-Register Write Bridge

This block sits as a slave on a request/response bus with a request channel (A) and a response channel (D). It takes register write requests one at a time. When a write targets the transmit-data register, its byte is offered to a serial transmitter over a valid/ready handshake. The bus response is withheld until the transmitter takes the byte. Software can therefore store bytes to that register in a tight loop: each store stalls in the bridge until the shifter is free, and no baud-rate timing is needed in software.

Writes to any other address, and requests that are not writes, are acknowledged on the next cycle without touching the transmitter. Only one request is in flight at a time. The request channel is ready only while the controller is idle. Arbitration between several masters happens outside this block.

Top module: `txreg_bridge`

## Requirements
- R1: Whenever reset is active, `a_ready` is 1, and `d_valid` and `tx_valid` are 0.
- R2: A request is accepted on a clock edge where `a_valid` and `a_ready` are both 1. `a_ready` is 1 only while idle, and it is 0 in the cycle after an acceptance.
- R3: An accepted request whose opcode is 0 (full write) or 1 (partial write), and whose address equals `TX_ADDR`, raises `tx_valid` in the next cycle. `tx_data` then carries the accepted data byte.
- R4: Any other accepted request raises `d_valid` in the next cycle, and `tx_valid` stays 0 for that request.
- R5: `tx_valid` and `tx_data` hold until a cycle with `tx_ready` = 1. In the cycle after that handshake, `tx_valid` is 0 and `d_valid` is 1.
- R6: `d_valid` holds until a cycle with `d_ready` = 1. In the cycle after that handshake, `d_valid` is 0 and `a_ready` is 1.
- R7: While `d_valid` is 1, `d_opcode` is 0 (access acknowledge). `d_source` and `d_size` equal the values of the accepted request and stay stable.
- R8: A request presented while `a_ready` is 0 is ignored. It does not change `tx_data`, `d_source` or `d_size` of the transaction in progress.
- R9: Exactly one of `a_ready`, `tx_valid` and `d_valid` is 1 in every cycle. The number of accepted requests equals the number of completed responses, plus zero or one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_valid | input | 1 | Request channel valid |
| a_ready | output | 1 | Request channel ready (idle) |
| a_opcode | input | 3 | Request opcode (0 full write, 1 partial write) |
| a_addr | input | ADDR_W | Request register address |
| a_data | input | DATA_W | Request write data |
| a_source | input | SRC_W | Request source ID |
| a_size | input | SZ_W | Request size field |
| d_valid | output | 1 | Response channel valid |
| d_ready | input | 1 | Response channel ready |
| d_opcode | output | 3 | Response opcode, always 0 |
| d_source | output | SRC_W | Echoed source ID |
| d_size | output | SZ_W | Echoed size field |
| tx_valid | output | 1 | Byte offered to the transmitter |
| tx_ready | input | 1 | Transmitter takes the byte |
| tx_data | output | DATA_W | Byte to transmit |

## Verification
If the controller held a wrong state, it would break the exclusivity of `a_ready`, `tx_valid` and `d_valid` at the ports in that same cycle. A missed or spurious transition would make a response appear one cycle early or late, or be lost altogether. A behavioural model compares all three handshake outputs, and the echoed fields, on every clock, so any such fault shows within one cycle of its cause. Latched fields that requests arriving mid-transaction overwrite would show as a changed `d_source` or `tx_data` while a handshake is still pending.

// File: rtl/txb_pkg.sv
package txb_pkg;
    typedef enum logic [2:0] {
        ST_IDLE = 3'b001,
        ST_WAIT = 3'b010,
        ST_ACK  = 3'b100
    } txb_state_e;

    localparam logic [2:0] OP_PUT_FULL   = 3'd0;
    localparam logic [2:0] OP_PUT_PART   = 3'd1;
    localparam logic [2:0] OP_ACCESS_ACK = 3'd0;
endpackage

// File: rtl/txb_decode.sv
module txb_decode #(
    parameter int unsigned ADDR_W  = 8,
    parameter logic [ADDR_W-1:0] TX_ADDR = '0
) (
    input  logic [2:0]        opcode,
    input  logic [ADDR_W-1:0] addr,
    output logic              is_tx_put
);
    import txb_pkg::*;

    logic is_put;

    always_comb begin
        is_put    = (opcode == OP_PUT_FULL) || (opcode == OP_PUT_PART);
        is_tx_put = is_put && (addr == TX_ADDR);
    end
endmodule

// File: rtl/txb_fsm.sv
module txb_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic a_valid,
    input  logic is_tx_put,
    input  logic tx_ready,
    input  logic d_ready,
    output logic st_idle,
    output logic st_wait,
    output logic st_ack,
    output logic accept
);
    import txb_pkg::*;

    txb_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        accept  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (a_valid) begin
                    accept  = 1'b1;
                    state_d = is_tx_put ? ST_WAIT : ST_ACK;
                end
            end
            ST_WAIT: if (tx_ready) state_d = ST_ACK;
            ST_ACK:  if (d_ready)  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign st_idle = state_q[0];
    assign st_wait = state_q[1];
    assign st_ack  = state_q[2];

    assert_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(state_q) == 1);

    assert_accept_leaves_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (a_valid && st_idle) |=> !st_idle);

    assert_wait_to_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_wait && tx_ready) |=> (st_ack && !st_wait));

    assert_ack_to_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_ack && d_ready) |=> st_idle);

    assert_ack_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_ack && !d_ready) |=> st_ack);
endmodule

// File: rtl/txb_req_hold.sv
module txb_req_hold #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned SRC_W  = 4,
    parameter int unsigned SZ_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] in_data,
    input  logic [SRC_W-1:0]  in_source,
    input  logic [SZ_W-1:0]   in_size,
    output logic [DATA_W-1:0] out_data,
    output logic [SRC_W-1:0]  out_source,
    output logic [SZ_W-1:0]   out_size
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [SRC_W-1:0]  source;
        logic [SZ_W-1:0]   size;
    } held_t;

    held_t held_q, held_d;

    always_comb begin
        held_d = held_q;
        if (load) begin
            held_d.data   = in_data;
            held_d.source = in_source;
            held_d.size   = in_size;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) held_q <= '0;
        else        held_q <= held_d;
    end

    assign out_data   = held_q.data;
    assign out_source = held_q.source;
    assign out_size   = held_q.size;

    assert_hold_when_idle_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(out_data) && $stable(out_source) && $stable(out_size)));
endmodule

// File: rtl/txreg_bridge.sv
module txreg_bridge #(
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned SRC_W   = 4,
    parameter int unsigned SZ_W    = 2,
    parameter logic [ADDR_W-1:0] TX_ADDR = 8'h04
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_valid,
    output logic              a_ready,
    input  logic [2:0]        a_opcode,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_data,
    input  logic [SRC_W-1:0]  a_source,
    input  logic [SZ_W-1:0]   a_size,
    output logic              d_valid,
    input  logic              d_ready,
    output logic [2:0]        d_opcode,
    output logic [SRC_W-1:0]  d_source,
    output logic [SZ_W-1:0]   d_size,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [DATA_W-1:0] tx_data
);
    import txb_pkg::*;

    logic is_tx_put;
    logic st_idle, st_wait, st_ack, accept;

    txb_decode #(.ADDR_W(ADDR_W), .TX_ADDR(TX_ADDR)) u_dec (
        .opcode    (a_opcode),
        .addr      (a_addr),
        .is_tx_put (is_tx_put)
    );

    txb_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .a_valid   (a_valid),
        .is_tx_put (is_tx_put),
        .tx_ready  (tx_ready),
        .d_ready   (d_ready),
        .st_idle   (st_idle),
        .st_wait   (st_wait),
        .st_ack    (st_ack),
        .accept    (accept)
    );

    txb_req_hold #(.DATA_W(DATA_W), .SRC_W(SRC_W), .SZ_W(SZ_W)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (accept),
        .in_data    (a_data),
        .in_source  (a_source),
        .in_size    (a_size),
        .out_data   (tx_data),
        .out_source (d_source),
        .out_size   (d_size)
    );

    assign a_ready  = st_idle;
    assign tx_valid = st_wait;
    assign d_valid  = st_ack;
    assign d_opcode = OP_ACCESS_ACK;

    assert_tx_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    assert_d_fields_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (d_valid && !d_ready) |=> (d_valid && $stable(d_source) && $stable(d_size)));

    assert_tx_put_route_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (a_valid && a_ready && is_tx_put) |=> (tx_valid && !d_valid));

    assert_other_route_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (a_valid && a_ready && !is_tx_put) |=> (d_valid && !tx_valid));
endmodule

// File: tb/sim_txreg_bridge.sv
module sim_txreg_bridge;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] TXA = 8'h04;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic a_valid = 1'b0, d_ready = 1'b0, tx_ready = 1'b0;
    logic a_ready, d_valid, tx_valid;
    logic [2:0] a_opcode = 3'd0, d_opcode;
    logic [7:0] a_addr = 8'h00, a_data = 8'h00, tx_data;
    logic [3:0] a_source = 4'd0, d_source;
    logic [1:0] a_size = 2'd0, d_size;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 1'b0;

    // behavioural reference
    int m_phase = 0;            // 0 idle, 1 waiting on transmitter, 2 responding
    logic [7:0] m_data = '0;
    logic [3:0] m_src = '0;
    logic [1:0] m_size = '0;
    int accepted = 0;
    int completed = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    txreg_bridge #(.TX_ADDR(TXA)) u0 (
        .clk(clk), .rst_n(rst_n),
        .a_valid(a_valid), .a_ready(a_ready), .a_opcode(a_opcode), .a_addr(a_addr),
        .a_data(a_data), .a_source(a_source), .a_size(a_size),
        .d_valid(d_valid), .d_ready(d_ready), .d_opcode(d_opcode),
        .d_source(d_source), .d_size(d_size),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_phase = 0;
        end else begin
            cycles++;
            case (m_phase)
                0: if (a_valid) begin
                    accepted++;
                    m_data = a_data; m_src = a_source; m_size = a_size;
                    m_phase = ((a_opcode == 3'd0 || a_opcode == 3'd1) && a_addr == TXA) ? 1 : 2;
                end
                1: if (tx_ready) m_phase = 2;
                default: if (d_ready) begin m_phase = 0; completed++; end
            endcase
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R2 a_ready", a_ready, m_phase == 0);
            check("R3/R5 tx_valid", tx_valid, m_phase == 1);
            check("R4/R6 d_valid", d_valid, m_phase == 2);
            if (m_phase == 1) check("R3 tx_data", tx_data, m_data);
            if (m_phase == 2) begin
                check("R7 d_opcode", d_opcode, 0);
                check("R7 d_source", d_source, m_src);
                check("R7 d_size", d_size, m_size);
            end
            check("R9 exactly one handshake output", a_ready + tx_valid + d_valid, 1);
            check("R9 outstanding", ((accepted - completed) == 0 || (accepted - completed) == 1), 1);
        end
    end

    always @(posedge clk) begin
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            fails++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected<150000 cycles", cycles);
            $display("test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic req(input logic [2:0] op, input logic [7:0] ad, input logic [7:0] dt,
                       input logic [3:0] src, input logic [1:0] sz);
        a_valid = 1'b1; a_opcode = op; a_addr = ad; a_data = dt; a_source = src; a_size = sz;
        tick();
        a_valid = 1'b0;
    endtask

    initial begin
        // R1: reset state
        repeat (3) tick();
        check("R1 a_ready", a_ready, 1);
        check("R1 d_valid", d_valid, 0);
        check("R1 tx_valid", tx_valid, 0);
        rst_n = 1'b1;
        tick();

        // R4: write to another register, acknowledged next cycle
        req(3'd0, 8'h10, 8'hAA, 4'd3, 2'd0);
        check("R4 d_valid after plain write", d_valid, 1);
        check("R4 no tx_valid", tx_valid, 0);
        check("R7 d_source", d_source, 3);
        // R8: request while busy is ignored
        a_valid = 1'b1; a_source = 4'd9; a_size = 2'd3; a_opcode = 3'd0; a_addr = TXA;
        tick(); tick();
        check("R6 d_valid held", d_valid, 1);
        check("R8 d_source unchanged", d_source, 3);
        check("R8 d_size unchanged", d_size, 0);
        a_valid = 1'b0; d_ready = 1'b1;
        tick();
        check("R6 a_ready after response", a_ready, 1);
        check("R6 d_valid dropped", d_valid, 0);
        d_ready = 1'b0;

        // R3/R5: transmit write with shifter busy
        req(3'd0, TXA, 8'h5C, 4'd7, 2'd0);
        for (int i = 0; i < 4; i++) begin
            check("R5 tx_valid held", tx_valid, 1);
            check("R5 tx_data held", tx_data, 8'h5C);
            check("R5 no early response", d_valid, 0);
            tick();
        end
        tx_ready = 1'b1;
        tick();
        tx_ready = 1'b0;
        check("R5 tx_valid dropped", tx_valid, 0);
        check("R5 response after handoff", d_valid, 1);
        check("R7 d_source tx", d_source, 7);
        d_ready = 1'b1;
        tick();
        d_ready = 1'b0;

        // R3: partial write with transmitter free
        tx_ready = 1'b1;
        req(3'd1, TXA, 8'h33, 4'd2, 2'd1);
        check("R3 tx_valid on partial write", tx_valid, 1);
        check("R3 tx_data", tx_data, 8'h33);
        tick();
        check("R5 fast response", d_valid, 1);
        tx_ready = 1'b0;
        d_ready = 1'b1;
        tick();

        // R4: non-write opcode at the transmit address
        d_ready = 1'b0;
        req(3'd4, TXA, 8'h77, 4'd5, 2'd2);
        check("R4 read-type not sent", tx_valid, 0);
        check("R4 read-type acked", d_valid, 1);
        d_ready = 1'b1;
        tick();

        // mixed traffic, compared against the model every cycle
        for (int i = 0; i < 4000; i++) begin
            a_valid  = ($urandom % 3) == 0;
            a_opcode = (($urandom % 4) == 0) ? 3'd4 : 3'($urandom % 2);
            a_addr   = (($urandom % 2) == 0) ? TXA : 8'($urandom);
            a_data   = 8'($urandom);
            a_source = 4'($urandom);
            a_size   = 2'($urandom);
            tx_ready = ($urandom % 4) == 0;
            d_ready  = ($urandom % 2) == 0;
            tick();
        end
        a_valid = 1'b0; tx_ready = 1'b1; d_ready = 1'b1;
        repeat (4) tick();
        check("R9 all requests completed", accepted - completed, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end
endmodule